// File: doc/BRIEF.md
# CEC Transmit Retry Controller

This block holds one outgoing CEC frame and runs the full transmit operation for it. The host fills a byte buffer, writes the frame length, sets a retry limit and then sets an enable bit. The controller pulses a start strobe to a separate bit-level transmitter, which serves the frame bytes out of the buffer on request and later returns a single result code for each attempt.

When an attempt fails because the frame was not acknowledged (NACK) or because the line was held low, the controller starts a new attempt by itself. It does not involve the host, and it keeps doing so until the programmed number of retries is used up. The operation ends in one of three ways: success, lost arbitration, or retries exhausted. Each outcome sets a sticky flag that feeds the interrupt line. Two 4-bit counters, packed into one readable register, record how many attempts failed for each cause.

The host reaches the block through a simple write port and a read port whose data is registered. Writes are ignored while an operation is in progress, except writes to the flag-clear register.

Top module: `cec_txr_top`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, `irq` is low and `tx_start` is low.
- R2: The frame buffer takes bytes at addresses 0x00–0x0F and cannot be read back (those reads return 0). `phy_byte` gives the buffer byte at `phy_idx` one cycle after the index is presented. Bits [4:0] of the length register (0x10) hold the total byte count, header included, and drive `phy_len`.
- R3: When the block is idle, writing a 1 to bit 0 of the enable register (0x12) makes `tx_start` pulse for one cycle, starting at the next clock edge. Bit 0 reads 1 until an outcome is reported.
- R4: `phy_res` is encoded as 0 = acknowledged, 1 = NACK, 2 = low drive, 3 = arbitration lost. An acknowledged result sets the done flag (bit 5 of 0x13) and clears the enable bit.
- R5: Arbitration loss ends the operation at once. No retry follows, only the arbitration flag (bit 4 of 0x13) is set, and the enable bit clears.
- R6: After a NACK or low-drive result, if retries remain, `tx_start` pulses again in the cycle after `phy_done`. The retry limit sits in bits [6:4] of 0x11, and an operation makes at most 1 + limit attempts.
- R7: When a NACK or low-drive result arrives with no retries left, the timeout flag (bit 3 of 0x13) is set and the enable bit clears. A limit of 0 allows one attempt only.
- R8: Register 0x14 holds the NACK count in bits [3:0] and the low-drive count in bits [7:4]. Both counts clear when an operation starts, and each saturates at 15.
- R9: Writing 1s to bits [5:3] of 0x13 clears the matching flags. If a flag is set in the same cycle that it is cleared, the set wins.
- R10: `irq` is high exactly when at least one of the three flags is set.
- R11: While an operation is in progress, writes to the buffer, length, retry and enable registers have no effect. A `phy_done` received while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 5 | Host read address |
| rd_data | output | 8 | Registered read data, valid one cycle after rd_addr |
| tx_start | output | 1 | One-cycle strobe that starts one attempt |
| phy_len | output | 5 | Frame length for the transmitter |
| phy_idx | input | 4 | Buffer index requested by the transmitter |
| phy_byte | output | 8 | Buffer byte at phy_idx, one cycle later |
| phy_done | input | 1 | Attempt finished strobe |
| phy_res | input | 2 | Attempt result code |
| irq | output | 1 | Interrupt, OR of the three flags |

## Verification
Two functions of this block can land in the same cycle: an attempt result that sets a flag, and a host write that clears the flags. The bench takes manual control of the transmitter side and drives `phy_done` with an acknowledged result in the very cycle that the host writes 0x38 to the flag register. The check passes if the done flag and `irq` stay set afterwards while any other flags are cleared. A second coincidence is tested the same way: a `phy_done` arrives while the block is idle, and the bench confirms that it changes nothing.

// File: rtl/cec_txr_pkg.sv
package cec_txr_pkg;
  typedef enum logic [1:0] {
    RES_ACK    = 2'd0,
    RES_NACK   = 2'd1,
    RES_LOWDRV = 2'd2,
    RES_ARB    = 2'd3
  } phy_res_e;

  localparam int CNT_W = 4;
  localparam int LIM_W = 3;
endpackage

// File: rtl/cec_txr_buf.sv
module cec_txr_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cec_txr_seq.sv
module cec_txr_seq
  import cec_txr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LIM_W-1:0] limit,
  input  logic             phy_done,
  input  logic [1:0]       phy_res,
  input  logic [2:0]       clr,
  output logic             busy,
  output logic             tx_start,
  output logic [CNT_W-1:0] nack_cnt,
  output logic [CNT_W-1:0] ldrv_cnt,
  output logic             flg_done,
  output logic             flg_arb,
  output logic             flg_tmo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] retries;
  logic             fail;
  logic             more;
  phy_res_e         res;

  assign res  = phy_res_e'(phy_res);
  assign fail = (res == RES_NACK) || (res == RES_LOWDRV);
  assign more = retries < limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_start <= 1'b0;
      retries  <= '0;
      nack_cnt <= '0;
      ldrv_cnt <= '0;
      flg_done <= 1'b0;
      flg_arb  <= 1'b0;
      flg_tmo  <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      flg_done <= flg_done & ~clr[2];
      flg_arb  <= flg_arb  & ~clr[1];
      flg_tmo  <= flg_tmo  & ~clr[0];
      if (!busy && go) begin
        busy     <= 1'b1;
        tx_start <= 1'b1;
        retries  <= '0;
        nack_cnt <= '0;
        ldrv_cnt <= '0;
      end else if (busy && phy_done) begin
        if (res == RES_ACK) begin
          busy     <= 1'b0;
          flg_done <= 1'b1;
        end else if (res == RES_ARB) begin
          busy    <= 1'b0;
          flg_arb <= 1'b1;
        end else if (fail) begin
          if (res == RES_NACK && nack_cnt != CNT_MAX) nack_cnt <= nack_cnt + 1'b1;
          if (res == RES_LOWDRV && ldrv_cnt != CNT_MAX) ldrv_cnt <= ldrv_cnt + 1'b1;
          if (more) begin
            retries  <= retries + 1'b1;
            tx_start <= 1'b1;
          end else begin
            busy    <= 1'b0;
            flg_tmo <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cec_txr_top.sv
module cec_txr_top
  import cec_txr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH + 5)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          tx_start,
  output logic [LW-1:0] phy_len,
  input  logic [IW-1:0] phy_idx,
  output logic [7:0]    phy_byte,
  input  logic          phy_done,
  input  logic [1:0]    phy_res,
  output logic          irq
);
  localparam logic [AW-1:0] A_LEN = AW'(DEPTH);
  localparam logic [AW-1:0] A_LIM = AW'(DEPTH + 1);
  localparam logic [AW-1:0] A_EN  = AW'(DEPTH + 2);
  localparam logic [AW-1:0] A_INT = AW'(DEPTH + 3);
  localparam logic [AW-1:0] A_CNT = AW'(DEPTH + 4);

  logic             busy;
  logic             go;
  logic [2:0]       clr;
  logic             buf_we;
  logic [LW-1:0]    len_q;
  logic [LIM_W-1:0] lim_q;
  logic [CNT_W-1:0] nack_cnt, ldrv_cnt;
  logic             flg_done, flg_arb, flg_tmo;

  assign buf_we = wr_en && !busy && (wr_addr < AW'(DEPTH));
  assign go     = wr_en && (wr_addr == A_EN) && wr_data[0];
  assign clr    = (wr_en && wr_addr == A_INT) ? wr_data[5:3] : 3'b000;

  cec_txr_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_addr[IW-1:0]),
    .wdata (wr_data),
    .raddr (phy_idx),
    .rdata (phy_byte)
  );

  cec_txr_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .limit    (lim_q),
    .phy_done (phy_done),
    .phy_res  (phy_res),
    .clr      (clr),
    .busy     (busy),
    .tx_start (tx_start),
    .nack_cnt (nack_cnt),
    .ldrv_cnt (ldrv_cnt),
    .flg_done (flg_done),
    .flg_arb  (flg_arb),
    .flg_tmo  (flg_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      lim_q <= '0;
    end else if (wr_en && !busy) begin
      if (wr_addr == A_LEN) len_q <= wr_data[LW-1:0];
      if (wr_addr == A_LIM) lim_q <= wr_data[4 +: LIM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        A_LEN:   rd_data <= 8'(len_q);
        A_LIM:   rd_data <= 8'({lim_q, 4'b0000});
        A_EN:    rd_data <= {7'd0, busy};
        A_INT:   rd_data <= {2'b00, flg_done, flg_arb, flg_tmo, 3'b000};
        A_CNT:   rd_data <= {ldrv_cnt, nack_cnt};
        default: rd_data <= '0;
      endcase
    end
  end

  assign phy_len = len_q;
  assign irq     = flg_done | flg_arb | flg_tmo;
endmodule

// File: rtl/cec_txr_chk.sv
module cec_txr_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       tx_start,
  input logic       phy_done,
  input logic [1:0] phy_res,
  input logic       irq,
  input logic       flg_arb,
  input logic [3:0] nack_cnt,
  input logic [3:0] ldrv_cnt
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> busy); // R3

  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
    busy && phy_done && phy_res == 2'd0 |=> !busy && irq); // R4

  AST_ARB_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
    busy && phy_done && phy_res == 2'd3 |=> !busy && !tx_start && flg_arb); // R5

  AST_FAIL_RETRY_OR_END: assert property (@(posedge clk) disable iff (rst)
    busy && phy_done && (phy_res == 2'd1 || phy_res == 2'd2) |=> tx_start || (!busy && irq)); // R6

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> nack_cnt == 4'd0 && ldrv_cnt == 4'd0); // R8
endmodule

bind cec_txr_top cec_txr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .tx_start (tx_start),
  .phy_done (phy_done),
  .phy_res  (phy_res),
  .irq      (irq),
  .flg_arb  (flg_arb),
  .nack_cnt (nack_cnt),
  .ldrv_cnt (ldrv_cnt)
);

// File: tb/tb_cec_txr_top.sv
module tb_cec_txr_top;
  localparam int A_LEN = 16, A_LIM = 17, A_EN = 18, A_INT = 19, A_CNT = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx_start;
  logic [4:0] phy_len;
  logic [3:0] phy_idx = '0;
  logic [7:0] phy_byte;
  logic       phy_done = 1'b0;
  logic [1:0] phy_res = '0;
  logic       irq;

  always #4 clk = ~clk;

  cec_txr_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_start(tx_start), .phy_len(phy_len),
    .phy_idx(phy_idx), .phy_byte(phy_byte), .phy_done(phy_done), .phy_res(phy_res),
    .irq(irq)
  );

  int total = 0, bad = 0, cyc = 0, starts = 0;
  bit mb, mfd, mfa, mft, mstart, mbyte_v;
  int mret, mn, ml, mlen, mlim, mrd, mbyte;
  int mbuf[16];
  bit mval[16];
  string mrd_tag = "R1";
  int res_q[$];
  bit auto_phy = 1'b1;
  int wait_c = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int rdmux(input int a);
    case (a)
      A_LEN:   return mlen;
      A_LIM:   return mlim << 4;
      A_EN:    return int'(mb);
      A_INT:   return (int'(mfd) << 5) | (int'(mfa) << 4) | (int'(mft) << 3);
      A_CNT:   return (ml << 4) | mn;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a == A_LIM) return "R6";
    if (a == A_EN)  return "R3";
    if (a == A_INT) return "R9";
    if (a == A_CNT) return "R8";
    return "R2";
  endfunction

  // reference model, one step per clock
  always @(posedge clk) begin
    if (rst) begin
      mb = 0; mfd = 0; mfa = 0; mft = 0; mstart = 0; mret = 0; mn = 0; ml = 0;
      mlen = 0; mlim = 0; mrd = 0; mrd_tag = "R1"; mbyte_v = 0;
      for (int i = 0; i < 16; i++) mval[i] = 0;
    end else begin
      bit [2:0] clrv;
      mrd = rdmux(int'(rd_addr));
      mrd_tag = tag_of(int'(rd_addr));
      mbyte = mbuf[phy_idx];
      mbyte_v = mval[phy_idx];
      clrv = (wr_en && wr_addr == A_INT) ? wr_data[5:3] : 3'b000;
      mstart = 0;
      if (clrv[2]) mfd = 0;
      if (clrv[1]) mfa = 0;
      if (clrv[0]) mft = 0;
      if (wr_en && !mb) begin
        if (wr_addr < 16) begin mbuf[wr_addr] = wr_data; mval[wr_addr] = 1; end
        if (wr_addr == A_LEN) mlen = wr_data & 8'h1f;
        if (wr_addr == A_LIM) mlim = (wr_data >> 4) & 7;
      end
      if (!mb && wr_en && wr_addr == A_EN && wr_data[0]) begin
        mb = 1; mstart = 1; mret = 0; mn = 0; ml = 0;
      end else if (mb && phy_done) begin
        case (phy_res)
          2'd0: begin mb = 0; mfd = 1; end
          2'd3: begin mb = 0; mfa = 1; end
          default: begin
            if (phy_res == 2'd1 && mn < 15) mn++;
            if (phy_res == 2'd2 && ml < 15) ml++;
            if (mret < mlim) begin mret++; mstart = 1; end
            else begin mb = 0; mft = 1; end
          end
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3/R6 tx_start", int'(tx_start), int'(mstart));
      chk("R10 irq", int'(irq), int'(mfd | mfa | mft));
      chk({mrd_tag, " rd_data"}, int'(rd_data), mrd);
      chk("R2 phy_len", int'(phy_len), mlen);
      if (mbyte_v) chk("R2 phy_byte", int'(phy_byte), mbyte);
      if (tx_start) starts++;
    end
  end

  // transmitter stand-in
  always @(negedge clk) begin
    if (auto_phy) begin
      phy_done = 1'b0;
      if (tx_start) wait_c = 6;
      else if (wait_c > 0) begin
        wait_c--;
        if (wait_c == 0) begin
          phy_done = 1'b1;
          phy_res = (res_q.size() > 0) ? 2'(res_q.pop_front()) : 2'd0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL R1 watchdog expired actual=%0d expected<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic host_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic wait_idle();
    while (mb) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int lim, input int exp_starts, input int exp_int,
                     input int exp_cnt, input string tag);
    host_wr(A_LIM, lim << 4);
    starts = 0;
    host_wr(A_EN, 1);
    wait_idle();
    chk({tag, " attempts"}, starts, exp_starts);
    expect_rd(A_INT, exp_int, tag);
    expect_rd(A_CNT, exp_cnt, "R8");
    expect_rd(A_EN, 0, tag);
    host_wr(A_INT, 8'h38);
    expect_rd(A_INT, 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx_start", int'(tx_start), 0);
    for (int a = A_LEN; a <= A_CNT; a++) expect_rd(a, 0, "R1");

    for (int i = 0; i < 16; i++) host_wr(i, i * 17 + 3);
    host_wr(A_LEN, 4);
    expect_rd(A_LEN, 4, "R2");
    expect_rd(3, 0, "R2");
    for (int i = 0; i < 16; i++) begin @(negedge clk); phy_idx = 4'(i); end

    res_q = {1, 2, 0};
    run(2, 3, 8'h20, 8'h11, "R4");
    res_q = {1, 1, 1};
    run(2, 3, 8'h08, 8'h03, "R7");
    res_q = {2};
    run(0, 1, 8'h08, 8'h10, "R7");
    res_q = {1, 3};
    run(3, 2, 8'h10, 8'h01, "R5");
    res_q = {2, 1, 0};
    run(7, 3, 8'h20, 8'h11, "R6");

    // R11: configuration writes during an operation
    host_wr(A_LIM, 8'h10);
    res_q = {1, 0};
    starts = 0;
    host_wr(A_EN, 1);
    host_wr(A_LEN, 9);
    host_wr(A_LIM, 8'h70);
    host_wr(0, 8'hEE);
    host_wr(A_EN, 1);
    wait_idle();
    chk("R11 attempts", starts, 2);
    expect_rd(A_LEN, 4, "R11");
    expect_rd(A_LIM, 8'h10, "R11");
    @(negedge clk); phy_idx = 4'd0;
    @(negedge clk); @(negedge clk);
    chk("R11 buffer byte", int'(phy_byte), 3);
    host_wr(A_INT, 8'h38);

    // manual transmitter: idle done, then coincident set and clear
    auto_phy = 1'b0;
    @(negedge clk);
    phy_done = 1'b1; phy_res = 2'd0;
    @(negedge clk);
    phy_done = 1'b0;
    @(negedge clk);
    chk("R11 idle done irq", int'(irq), 0);
    expect_rd(A_INT, 0, "R11");
    host_wr(A_EN, 1);
    repeat (2) @(negedge clk);
    phy_done = 1'b1; phy_res = 2'd0;
    wr_en = 1'b1; wr_addr = 5'(A_INT); wr_data = 8'h38;
    @(negedge clk);
    phy_done = 1'b0; wr_en = 1'b0;
    chk("R9 set wins irq", int'(irq), 1);
    expect_rd(A_INT, 8'h20, "R9");
    host_wr(A_INT, 8'h20);
    expect_rd(A_INT, 0, "R9");
    chk("R10 irq low", int'(irq), 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule